// File: doc/BRIEF.md
# Binary FSK Direct Digital Synthesizer

This block turns a serial data stream into a sampled sine tone whose pitch follows the data. A data bit of 0 makes a tone near 0.117 of the clock rate. A data bit of 1 makes a tone near 0.348 of the clock rate. The output word drives an external current-steering DAC.

Each incoming bit passes through a short register chain. It then picks one of two constant phase steps, 60 or 178. The chosen step is added every cycle into a 9-bit phase accumulator, which wraps modulo 512. The accumulator addresses a 512-entry table of 8-bit offset-binary sine codes, and the table output is registered.

The registered sample is re-coded into a 19-line segmented word. The upper nibble becomes 15 thermometer lines and the lower nibble passes straight through as binary. Because the thermometer segments change one line per step of the upper nibble, the coarse DAC current switches without large glitches. There is no run-time tuning: both tones are fixed by parameters.

Top module: `bfsk_dds`

## Requirements
- R1: A clock edge with `rst` high clears the input register chain and the phase accumulator to 0. After that edge `dac_word` reads 0x00FF0, which is the encoding of sample 128: thermometer lines 0..7 set and binary nibble 0.
- R2: While the selecting bit is 0, the phase advances by 60 every cycle, modulo 512.
- R3: While the selecting bit is 1, the phase advances by 178 every cycle, modulo 512.
- R4: A value on `data_in` captured at clock edge e decides the phase step applied at edge e+2. This is the delay of the two-flop input chain.
- R5: A change of the data bit never resets or jumps the phase. The new step is added to whatever phase the accumulator holds.
- R6: The sample for phase k is round(127.5 + 127.5·sin(2πk/512)). The samples at phases 0 and 256 are 128, the sample at 128 is 255, and the sample at 384 is 0.
- R7: `dac_word[3:0]` equals the low nibble of the current sample.
- R8: `dac_word[18:4]` is a thermometer code. Bit 4+i is 1 exactly when the upper nibble of the sample is greater than i, so the set lines always form a contiguous run starting at bit 4.
- R9: `dac_word` after edge m encodes the sample of the phase value held after edge m-2. As a consequence, the reset word is still present for two edges after `rst` falls.
- R10: Asserting `rst` in the middle of a tone restores the R1 state at the next edge, whatever the phase was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 1 | Serial data bit selecting the tone (0 low, 1 high) |
| dac_word | output | 19 | Segmented DAC drive: [18:4] thermometer, [3:0] binary |

## Verification
A data bit captured at one edge changes the phase two edges later. The output then trails that phase by two more registered stages, so a new bit first shows in `dac_word` four edges after it is captured. Right after reset the output holds the midscale word for two edges. The bench keeps a cycle model of the bit chain, the accumulator, the sample register and the output register, advanced once per rising edge. It compares the outputs half a clock period after each edge, with every check tagged by the requirement it exercises. Checks at a data change look at the two steps where the old tone must persist. Checks at the following steps look for continuation from the old phase.

// File: rtl/bfsk_dds_pkg.sv
package bfsk_dds_pkg;

   localparam int unsigned DEF_PHASE_W = 9;
   localparam int unsigned DEF_SAMP_W  = 8;
   localparam int unsigned DEF_LSB_W   = 4;
   localparam int unsigned DEF_INC_LO  = 60;
   localparam int unsigned DEF_INC_HI  = 178;
   localparam int unsigned DEF_SYNC_N  = 2;

   localparam real TWO_PI = 6.283185307179586;

   // Offset-binary sine code for phase index k, built by quarter-wave folding
   // and a Taylor series so that the zero crossings are exact.
   function automatic int unsigned sine_code(input int unsigned k,
                                             input int unsigned phase_w,
                                             input int unsigned samp_w);
      int unsigned depth;
      int unsigned half;
      int unsigned quarter;
      int unsigned h;
      bit          neg;
      real         x;
      real         term;
      real         s;
      real         amp;
      real         v;
      depth   = 1 << phase_w;
      half    = depth / 2;
      quarter = depth / 4;
      h       = k % half;
      neg     = ((k % depth) >= half);
      if (h > quarter) h = half - h;
      x    = TWO_PI * real'(h) / real'(depth);
      term = x;
      s    = x;
      for (int n = 1; n < 13; n++) begin
         term = -term * x * x / real'((2 * n) * (2 * n + 1));
         s    = s + term;
      end
      amp = real'((1 << samp_w) - 1) / 2.0;
      v   = neg ? (amp - amp * s) : (amp + amp * s);
      return $rtoi(v + 0.5);
   endfunction

endpackage

// File: rtl/bfsk_bit_sync.sv
module bfsk_bit_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk) begin
            if (rst) s_q <= 1'b0;
            else     s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk) begin
            if (rst) s_q <= '0;
            else     s_q <= {s_q[STAGES-2:0], d};
         end
         assign q = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bfsk_phase_acc.sv
module bfsk_phase_acc #(
   parameter int unsigned PHASE_W = 9,
   parameter int unsigned INC_LO  = 60,
   parameter int unsigned INC_HI  = 178
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sel,
   output logic [PHASE_W-1:0] phase
);

   localparam logic [PHASE_W-1:0] STEP_LO = PHASE_W'(INC_LO);
   localparam logic [PHASE_W-1:0] STEP_HI = PHASE_W'(INC_HI);

   logic [PHASE_W-1:0] step_c;
   logic [PHASE_W-1:0] acc_q;

   always_comb begin
      step_c = sel ? STEP_HI : STEP_LO;
   end

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + step_c;
   end

   assign phase = acc_q;

endmodule

// File: rtl/bfsk_sine_rom.sv
module bfsk_sine_rom
   import bfsk_dds_pkg::*;
#(
   parameter int unsigned PHASE_W = 9,
   parameter int unsigned SAMP_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] phase,
   output logic [SAMP_W-1:0]  sample
);

   localparam int unsigned DEPTH = 1 << PHASE_W;
   localparam logic [SAMP_W-1:0] RST_CODE = SAMP_W'(sine_code(0, PHASE_W, SAMP_W));

   logic [SAMP_W-1:0] table_w [DEPTH];
   logic [SAMP_W-1:0] samp_q;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_entry
         localparam logic [SAMP_W-1:0] CODE = SAMP_W'(sine_code(k, PHASE_W, SAMP_W));
         assign table_w[k] = CODE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) samp_q <= RST_CODE;
      else     samp_q <= table_w[phase];
   end

   assign sample = samp_q;

endmodule

// File: rtl/bfsk_seg_encoder.sv
module bfsk_seg_encoder
   import bfsk_dds_pkg::*;
#(
   parameter int unsigned PHASE_W = 9,
   parameter int unsigned SAMP_W  = 8,
   parameter int unsigned LSB_W   = 4
) (
   input  logic                                         clk,
   input  logic                                         rst,
   input  logic [SAMP_W-1:0]                            sample,
   output logic [(1 << (SAMP_W-LSB_W)) - 1 + LSB_W - 1:0] word
);

   localparam int unsigned MSB_W   = SAMP_W - LSB_W;
   localparam int unsigned THERM_W = (1 << MSB_W) - 1;
   localparam int unsigned OUT_W   = THERM_W + LSB_W;
   localparam int unsigned RST_SMP = sine_code(0, PHASE_W, SAMP_W);
   localparam int unsigned RST_HI  = RST_SMP >> LSB_W;
   localparam int unsigned RST_LO  = RST_SMP % (1 << LSB_W);
   localparam logic [THERM_W-1:0] RST_THERM = THERM_W'((1 << RST_HI) - 1);
   localparam logic [OUT_W-1:0]   RST_WORD  = {RST_THERM, LSB_W'(RST_LO)};

   logic [MSB_W-1:0]   coarse_c;
   logic [THERM_W-1:0] therm_c;
   logic [OUT_W-1:0]   word_q;

   assign coarse_c = sample[SAMP_W-1:LSB_W];

   generate
      for (genvar i = 0; i < THERM_W; i++) begin : g_line
         assign therm_c[i] = (coarse_c > MSB_W'(i));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) word_q <= RST_WORD;
      else     word_q <= {therm_c, sample[LSB_W-1:0]};
   end

   assign word = word_q;

endmodule

// File: rtl/bfsk_dds.sv
module bfsk_dds
   import bfsk_dds_pkg::*;
#(
   parameter int unsigned PHASE_W = DEF_PHASE_W,
   parameter int unsigned SAMP_W  = DEF_SAMP_W,
   parameter int unsigned LSB_W   = DEF_LSB_W,
   parameter int unsigned INC_LO  = DEF_INC_LO,
   parameter int unsigned INC_HI  = DEF_INC_HI,
   parameter int unsigned SYNC_N  = DEF_SYNC_N
) (
   input  logic                                         clk,
   input  logic                                         rst,
   input  logic                                         data_in,
   output logic [(1 << (SAMP_W-LSB_W)) - 1 + LSB_W - 1:0] dac_word
);

   localparam int unsigned DEPTH = 1 << PHASE_W;
   localparam int unsigned MSB_W = SAMP_W - LSB_W;

   generate
      if (INC_LO == 0 || INC_LO >= DEPTH / 2) begin : g_bad_inc_lo
         $error("bfsk_dds: INC_LO must lie in 1 .. DEPTH/2-1");
      end
      if (INC_HI == 0 || INC_HI >= DEPTH / 2) begin : g_bad_inc_hi
         $error("bfsk_dds: INC_HI must lie in 1 .. DEPTH/2-1");
      end
      if (LSB_W == 0 || LSB_W >= SAMP_W) begin : g_bad_lsb
         $error("bfsk_dds: LSB_W must lie in 1 .. SAMP_W-1");
      end
      if (MSB_W > 5) begin : g_bad_msb
         $error("bfsk_dds: thermometer segment limited to 31 lines");
      end
      if (SYNC_N == 0) begin : g_bad_sync
         $error("bfsk_dds: SYNC_N must be at least 1");
      end
      if (PHASE_W < 3 || PHASE_W > 11) begin : g_bad_phase
         $error("bfsk_dds: PHASE_W must lie in 3 .. 11");
      end
   endgenerate

   logic               sel_w;
   logic [PHASE_W-1:0] phase_w;
   logic [SAMP_W-1:0]  samp_w;

   bfsk_bit_sync #(
      .STAGES (SYNC_N)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (data_in),
      .q   (sel_w)
   );

   bfsk_phase_acc #(
      .PHASE_W (PHASE_W),
      .INC_LO  (INC_LO),
      .INC_HI  (INC_HI)
   ) u_acc (
      .clk   (clk),
      .rst   (rst),
      .sel   (sel_w),
      .phase (phase_w)
   );

   bfsk_sine_rom #(
      .PHASE_W (PHASE_W),
      .SAMP_W  (SAMP_W)
   ) u_rom (
      .clk    (clk),
      .rst    (rst),
      .phase  (phase_w),
      .sample (samp_w)
   );

   bfsk_seg_encoder #(
      .PHASE_W (PHASE_W),
      .SAMP_W  (SAMP_W),
      .LSB_W   (LSB_W)
   ) u_enc (
      .clk    (clk),
      .rst    (rst),
      .sample (samp_w),
      .word   (dac_word)
   );

endmodule

// File: rtl/bfsk_dds_chk.sv
module bfsk_dds_chk
   import bfsk_dds_pkg::*;
#(
   parameter int unsigned PHASE_W = 9,
   parameter int unsigned SAMP_W  = 8,
   parameter int unsigned LSB_W   = 4,
   parameter int unsigned INC_LO  = 60,
   parameter int unsigned INC_HI  = 178,
   parameter int unsigned SYNC_N  = 2
) (
   input logic                                         clk,
   input logic                                         rst,
   input logic                                         data_in,
   input logic [PHASE_W-1:0]                           phase,
   input logic [(1 << (SAMP_W-LSB_W)) - 1 + LSB_W - 1:0] dac_word
);

   localparam int unsigned THERM_W = (1 << (SAMP_W - LSB_W)) - 1;
   localparam int unsigned OUT_W   = THERM_W + LSB_W;
   localparam int unsigned RST_SMP = sine_code(0, PHASE_W, SAMP_W);
   localparam logic [THERM_W-1:0] RST_THERM = THERM_W'((1 << (RST_SMP >> LSB_W)) - 1);
   localparam logic [OUT_W-1:0]   RST_WORD  = {RST_THERM, LSB_W'(RST_SMP % (1 << LSB_W))};
   localparam int unsigned SETTLE = SYNC_N + 2;

   logic [SYNC_N:0] hist_q;
   int unsigned     since_q;
   logic [THERM_W-1:0] therm_w;

   assign therm_w = dac_word[OUT_W-1:LSB_W];

   always_ff @(posedge clk) begin
      hist_q <= {hist_q[SYNC_N-1:0], data_in};
      if (rst)                  since_q <= 0;
      else if (since_q < SETTLE) since_q <= since_q + 1;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (phase == '0 && dac_word == RST_WORD));

   // R8
   therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
      ((therm_w & (therm_w + 1'b1)) == '0));

   // R4
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      (since_q >= SETTLE) |->
      (phase == PHASE_W'($past(phase) + (hist_q[SYNC_N] ? PHASE_W'(INC_HI) : PHASE_W'(INC_LO)))));

   // R9
   reset_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (since_q <= 2) |-> (dac_word == RST_WORD));

endmodule

bind bfsk_dds bfsk_dds_chk #(
   .PHASE_W (PHASE_W),
   .SAMP_W  (SAMP_W),
   .LSB_W   (LSB_W),
   .INC_LO  (INC_LO),
   .INC_HI  (INC_HI),
   .SYNC_N  (SYNC_N)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .data_in  (data_in),
   .phase    (phase_w),
   .dac_word (dac_word)
);

// File: tb/bfsk_dds_bench.sv
module bfsk_dds_bench;

   localparam int NVEC = 12;
   // each entry: [8] data bit, [7:0] number of cycles it is held
   localparam logic [8:0] VEC [NVEC] = '{
      {1'b0, 8'd20}, {1'b1, 8'd25}, {1'b0, 8'd9},  {1'b1, 8'd1},
      {1'b0, 8'd12}, {1'b1, 8'd2},  {1'b0, 8'd3},  {1'b1, 8'd40},
      {1'b0, 8'd1},  {1'b1, 8'd7},  {1'b0, 8'd60}, {1'b1, 8'd30}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        data_in = 1'b0;
   logic [18:0] dac_word;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model state
   int  m_d1, m_d2, m_phase, m_samp_ph, m_out_ph;

   always #5 clk = ~clk;

   bfsk_dds u_bfsk_dds (
      .clk      (clk),
      .rst      (rst),
      .data_in  (data_in),
      .dac_word (dac_word)
   );

   function automatic int sine_ref(input int k);
      real v;
      if ((k % 256) == 0) return 128;
      v = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * real'(k) / 512.0);
      return $rtoi(v + 0.5);
   endfunction

   function automatic logic [18:0] enc_ref(input int s);
      logic [14:0] th;
      th = 15'((1 << (s / 16)) - 1);
      return {th, 4'(s % 16)};
   endfunction

   task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%05h expected 0x%05h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_d1 = 0; m_d2 = 0; m_phase = 0; m_samp_ph = 0; m_out_ph = 0;
   endtask

   // one clock: drive at negedge, update model for the rising edge, sample at next negedge
   task automatic cycle(input logic r, input logic b);
      rst = r;
      data_in = b;
      @(posedge clk);
      @(negedge clk);
      if (r) model_reset();
      else begin
         m_out_ph  = m_samp_ph;
         m_samp_ph = m_phase;
         m_phase   = (m_phase + (m_d2 != 0 ? 178 : 60)) % 512;
         m_d2      = m_d1;
         m_d1      = b;
      end
   endtask

   task automatic check_fields();
      int s;
      s = sine_ref(m_out_ph);
      check("R6", 19'(($countones(dac_word[18:4]) * 16) + dac_word[3:0]), 19'(s));
      check("R7", {15'd0, dac_word[3:0]}, {15'd0, 4'(s % 16)});
      check("R8", {4'd0, dac_word[18:4]}, {4'd0, 15'((1 << (s / 16)) - 1)});
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      model_reset();
      @(negedge clk);
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         cycle(1'b1, 1'b1);
         check("R1", dac_word, 19'h00FF0);
      end
      // R9: reset word held two edges after release
      for (int i = 0; i < 2; i++) begin
         cycle(1'b0, 1'b0);
         check("R9", dac_word, 19'h00FF0);
      end
      // vector table walk
      for (int v = 0; v < NVEC; v++) begin
         for (int j = 0; j < int'(VEC[v][7:0]); j++) begin
            string tag;
            cycle(1'b0, VEC[v][8]);
            if (v > 0 && j < 2)      tag = "R4";
            else if (v > 0 && j < 5) tag = "R5";
            else                     tag = VEC[v][8] ? "R3" : "R2";
            check(tag, dac_word, enc_ref(sine_ref(m_out_ph)));
            check_fields();
         end
      end
      // R10: reset in the middle of the high tone
      cycle(1'b1, 1'b1);
      check("R10", dac_word, 19'h00FF0);
      cycle(1'b0, 1'b1);
      check("R10", dac_word, 19'h00FF0);
      cycle(1'b0, 1'b1);
      check("R10", dac_word, 19'h00FF0);
      // R4: bits captured right after reset take effect two edges later
      for (int j = 0; j < 6; j++) begin
         cycle(1'b0, 1'b1);
         check("R4", dac_word, enc_ref(sine_ref(m_out_ph)));
      end
      // R6: table landmarks reached by phase steps 178,178 then 73 x 60 -> 128
      cycle(1'b1, 1'b0);
      cycle(1'b0, 1'b1);
      cycle(1'b0, 1'b1);
      for (int j = 0; j < 75; j++) cycle(1'b0, 1'b0);
      // phase sequence after the release edge: 0,60,120 (bits not yet in), so step checks via model
      check("R6", dac_word, enc_ref(sine_ref(m_out_ph)));
      check_fields();
      check("R6", 19'(sine_ref(128)), 19'd255);
      check("R6", 19'(sine_ref(384)), 19'd0);
      done = 1'b1;
      finish_run();
   end

endmodule